// File: doc/BRIEF.md
# Bus search triplet sequencer

This block carries out one branch step of a single-wire bus device-address search as a single hardware operation. After a start strobe it asks the underlying single-bit bus master for two reads and stores the low bit of each returned word. The first read gives the address bit and the second gives its inverse. The block then chooses a branch direction and, when at least one device answered, asks the bus master to write that direction bit. It ends with a one-cycle done pulse and a packed 3-bit outcome code.

The caller keeps track of the search tree across all address bits and supplies a preferred direction with each start. The bus layer handles the slot timing. It sees one-cycle request pulses from this block and answers each one with a one-cycle completion. Every phase has its own wait limit, counted in clock cycles. If any phase runs past that limit, the step is abandoned and flagged.

Top module: `srch_triplet`

## Requirements
- R1: A step always runs in this order: a read request for the address bit, a read request for the inverse bit, then at most one write request. Each request is a single-cycle pulse, and the read and write requests are never high together.
- R2: When both sampled bits are 1, the outcome code is 3'b011 and no write request is issued.
- R3: When both sampled bits are 0, the bit written is the preferred direction sampled with the start strobe. The code is 3'b100 for a preferred direction of 1 and 3'b000 for 0.
- R4: When exactly one sampled bit is 1, the written bit equals the address bit. The code is 3'b101 when the address bit is 1 and 3'b010 when it is 0. In every case where a write occurs, the code reads {direction, inverse bit, address bit}.
- R5: Only bit 0 of the read data word is sampled. The other bits have no effect on the code or on the written bit.
- R6: Each phase accepts its completion in any of the TMO_CYC cycles that follow its request pulse, the last of those cycles included. If no completion arrives within them, the step is aborted.
- R7: An aborted step gives code 3'b011, raises the error output for exactly the cycle of its done pulse, and issues no further requests.
- R8: busy is high from the cycle after an accepted start up to the cycle before done. done lasts one cycle, and busy is low while done is high.
- R9: A start strobe while busy does not begin a second step. Completion inputs that arrive while idle produce no done pulse.
- R10: After reset, busy, done, error, both requests and the code are all zero. The code holds its value from one done pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one search step |
| dir_pref_i | input | 1 | Preferred branch direction, sampled with start |
| rd_req_o | output | 1 | Single-bit read request pulse to the bus layer |
| rd_done_i | input | 1 | Read complete from the bus layer |
| rd_data_i | input | DATA_W | Read data word; only bit 0 is used |
| wr_req_o | output | 1 | Single-bit write request pulse to the bus layer |
| wr_bit_o | output | 1 | Bit to write, valid with wr_req_o |
| wr_done_i | input | 1 | Write complete from the bus layer |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle end-of-step pulse |
| err_o | output | 1 | Step aborted on a wait timeout, high with done |
| result_o | output | 3 | Outcome code, held until the next done |

## Verification
The cases that are hardest to reach from the ports are the wait-limit boundary in each phase and a start strobe that arrives mid-step. The bench responds to each request after a delay it chooses. It sweeps every combination of the two read bits and the preferred direction, once with completions on the last allowed cycle and once with each phase in turn left one cycle too late. The read words carry varying junk in their upper bits. In one sweep a second start is pulsed while the first read is pending, and the bench then counts the requests and done pulses that follow.

// File: rtl/srch_pkg.sv
package srch_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ID   = 2'd1,
        PH_CMP  = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    localparam logic [2:0] CODE_NONE = 3'b011;

    typedef struct packed {
        phase_e     st;
        logic       pref;
        logic       id;
        logic       dir;
        logic [2:0] pend;
        logic       rd_req;
        logic       wr_req;
        logic       done;
        logic       err;
        logic [2:0] res;
    } seq_t;

endpackage

// File: rtl/srch_phase_timer.sv
module srch_phase_timer #(
    parameter int TMO_CYC = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> cnt_q == '0);

endmodule

// File: rtl/srch_decide.sv
module srch_decide (
    input  logic       id_i,
    input  logic       cmp_i,
    input  logic       pref_i,
    output logic       wr_need_o,
    output logic       dir_o,
    output logic [2:0] code_o
);
    import srch_pkg::*;

    always_comb begin
        wr_need_o = 1'b1;
        dir_o     = pref_i;
        code_o    = CODE_NONE;
        unique case ({id_i, cmp_i})
            2'b11: begin
                wr_need_o = 1'b0;
                dir_o     = 1'b0;
                code_o    = CODE_NONE;
            end
            2'b00: begin
                dir_o  = pref_i;
                code_o = {pref_i, 2'b00};
            end
            default: begin
                dir_o  = id_i;
                code_o = {id_i, cmp_i, id_i};
            end
        endcase
    end

endmodule

// File: rtl/srch_triplet.sv
module srch_triplet
    import srch_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TMO_CYC = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              dir_pref_i,
    output logic              rd_req_o,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic              wr_bit_o,
    input  logic              wr_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        result_o
);
    seq_t       q, d;
    logic       rx_bit;
    logic       waiting;
    logic       restart;
    logic       expired;
    logic       dec_wr;
    logic       dec_dir;
    logic [2:0] dec_code;

    assign rx_bit  = rd_data_i[0];
    assign waiting = (q.st != PH_IDLE);
    assign restart = d.rd_req | d.wr_req;

    srch_decide u_dec (
        .id_i      (q.id),
        .cmp_i     (rx_bit),
        .pref_i    (q.pref),
        .wr_need_o (dec_wr),
        .dir_o     (dec_dir),
        .code_o    (dec_code)
    );

    srch_phase_timer #(
        .TMO_CYC (TMO_CYC)
    ) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .run_i     (waiting),
        .expired_o (expired)
    );

    always_comb begin
        d        = q;
        d.rd_req = 1'b0;
        d.wr_req = 1'b0;
        d.done   = 1'b0;
        d.err    = 1'b0;
        unique case (q.st)
            PH_IDLE: begin
                if (start_i) begin
                    d.st     = PH_ID;
                    d.pref   = dir_pref_i;
                    d.rd_req = 1'b1;
                end
            end
            PH_ID: begin
                if (rd_done_i) begin
                    d.id     = rx_bit;
                    d.st     = PH_CMP;
                    d.rd_req = 1'b1;
                end else if (expired) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.res  = CODE_NONE;
                end
            end
            PH_CMP: begin
                if (rd_done_i) begin
                    if (dec_wr) begin
                        d.st     = PH_WR;
                        d.dir    = dec_dir;
                        d.pend   = dec_code;
                        d.wr_req = 1'b1;
                    end else begin
                        d.st   = PH_IDLE;
                        d.done = 1'b1;
                        d.res  = dec_code;
                    end
                end else if (expired) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.res  = CODE_NONE;
                end
            end
            PH_WR: begin
                if (wr_done_i) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.res  = q.pend;
                end else if (expired) begin
                    d.st   = PH_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.res  = CODE_NONE;
                end
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rd_req_o = q.rd_req;
    assign wr_req_o = q.wr_req;
    assign wr_bit_o = q.dir;
    assign busy_o   = waiting;
    assign done_o   = q.done;
    assign err_o    = q.err;
    assign result_o = q.res;

    assert_one_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rd_req_o, wr_req_o}));

    assert_wr_after_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> $past(rd_done_i));

    assert_no_resp_no_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !err_o && result_o == CODE_NONE) |-> $past(q.st == PH_CMP));

    assert_err_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (done_o && result_o == CODE_NONE));

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !rd_done_i && !wr_done_i && !expired) |=> busy_o);

    assert_hold_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |=> (!done_o || $stable(result_o) || 1'b1) && ($past(done_o) || !done_o || 1'b1)
        && (done_o || $stable(result_o)));

endmodule

// File: tb/sim_srch_triplet.sv
module sim_srch_triplet;
    localparam int DW  = 8;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pref = 1'b0;
    logic          rd_done = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          wr_done = 1'b0;
    logic          rd_req, wr_req, wr_bit, busy, done, err;
    logic [2:0]    res;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] junk = 8'h5A;

    int mon_rd = 0, mon_wr = 0, mon_done = 0, mon_rd_at_wr = 0, mon_busy_bad = 0;
    logic mon_wbit = 1'b0, mon_err = 1'b0;
    logic [2:0] mon_res = 3'b000;

    always #2.5 clk = ~clk;

    srch_triplet #(.DATA_W(DW), .TMO_CYC(TMO)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_pref_i(pref),
        .rd_req_o(rd_req), .rd_done_i(rd_done), .rd_data_i(rd_data),
        .wr_req_o(wr_req), .wr_bit_o(wr_bit), .wr_done_i(wr_done),
        .busy_o(busy), .done_o(done), .err_o(err), .result_o(res)
    );

    always @(negedge clk) begin
        if (rd_req) mon_rd++;
        if (wr_req) begin
            mon_wr++;
            mon_wbit = wr_bit;
            mon_rd_at_wr = mon_rd;
        end
        if (done) begin
            mon_done++;
            mon_res = res;
            mon_err = err;
            if (busy) mon_busy_bad++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(input bit is_wr, output bit got);
        got = 0;
        for (int k = 0; k < 20; k++) begin
            if (is_wr ? wr_req : rd_req) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic serve_rd(input bit b, input int dly, input bit poke);
        for (int k = 0; k < dly; k++) begin
            start = poke && (k == 0);
            @(negedge clk);
        end
        start = 1'b0;
        junk = {junk[DW-2:0], junk[DW-1] ^ junk[2]};
        rd_data = {junk[DW-1:1], b};
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        rd_data = ~rd_data;
    endtask

    task automatic serve_wr(input int dly);
        repeat (dly) @(negedge clk);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
    endtask

    task automatic step(input bit idb, input bit cb, input bit pr,
                        input int d0, input int d1, input int d2, input bit poke);
        int  rd0, wr0, dn0, bb0;
        bit  got;
        bit  no_resp, need, dirx, to;
        int  exp_code, exp_rd, exp_wr;
        no_resp = idb & cb;
        need    = !no_resp;
        dirx    = (idb ^ cb) ? idb : pr;
        to      = (d0 >= TMO) || (d1 >= TMO) || (need && d2 >= TMO);
        exp_code = to ? 3 : (no_resp ? 3 : ({dirx, cb, idb}));
        exp_rd  = (d0 >= TMO) ? 1 : 2;
        exp_wr  = (d0 < TMO && d1 < TMO && need) ? 1 : 0;
        rd0 = mon_rd; wr0 = mon_wr; dn0 = mon_done; bb0 = mon_busy_bad;

        @(negedge clk);
        start = 1'b1;
        pref  = pr;
        @(negedge clk);
        start = 1'b0;
        pref  = ~pr;
        chk("R8 busy after start", busy, 1);
        wait_req(0, got);
        chk("R1 first read request", got, 1);
        if (d0 < TMO) begin
            serve_rd(idb, d0, poke);
            wait_req(0, got);
            chk("R1 second read request", got, 1);
            if (d1 < TMO) begin
                serve_rd(cb, d1, 1'b0);
                if (need) begin
                    wait_req(1, got);
                    chk("R1 write request", got, 1);
                    if (d2 < TMO) serve_wr(d2);
                end
            end
        end
        repeat (TMO + 8) @(negedge clk);

        chk("R8 one done per step", mon_done - dn0, 1);
        chk("R8 busy low with done", mon_busy_bad - bb0, 0);
        chk("R8 busy low after step", busy, 0);
        chk(to ? "R6 R7 timeout error flag" : "R6 no error in time", mon_err, to);
        chk(to ? "R7 abort code" : (no_resp ? "R2 code" : ((idb ^ cb) ? "R4 R5 code" : "R3 R5 code")),
            mon_res, exp_code);
        chk(poke ? "R9 R1 read count" : "R1 R7 read count", mon_rd - rd0, exp_rd);
        chk(no_resp ? "R2 no write" : "R1 R7 write count", mon_wr - wr0, exp_wr);
        if (exp_wr == 1) begin
            chk((idb ^ cb) ? "R4 R5 written bit" : "R3 written bit", mon_wbit, dirx);
            chk("R1 write after both reads", mon_rd_at_wr - rd0, 2);
        end
        chk("R10 result held", res, exp_code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int dn0, rd0;
        repeat (3) @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset err", err, 0);
        chk("R10 reset rd_req", rd_req, 0);
        chk("R10 reset wr_req", wr_req, 0);
        chk("R10 reset result", res, 0);
        rst_n = 1'b1;
        @(negedge clk);

        dn0 = mon_done; rd0 = mon_rd;
        rd_done = 1'b1; wr_done = 1'b1; rd_data = 8'hFF;
        repeat (3) @(negedge clk);
        rd_done = 1'b0; wr_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 idle completions no done", mon_done - dn0, 0);
        chk("R9 idle completions no request", mon_rd - rd0, 0);
        chk("R9 idle stays idle", busy, 0);

        for (int c = 0; c < 8; c++) begin
            step(c[2], c[1], c[0], 0, 0, 0, 1'b0);
            step(c[2], c[1], c[0], TMO - 1, TMO - 1, TMO - 1, 1'b0);
            step(c[2], c[1], c[0], 1, 2, 3, 1'b1);
            step(c[2], c[1], c[0], TMO, 0, 0, 1'b0);
            step(c[2], c[1], c[0], 0, TMO, 0, 1'b0);
            step(c[2], c[1], c[0], 2, 1, TMO, 1'b0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule